// File: doc/BRIEF.md
# SPI Slave-Select Manager

This unit decides where the select of an SPI peripheral comes from and what happens on the external slave-select pin. Five configuration inputs set its behaviour: a peripheral enable, a master/slave bit, a bit that picks software select, a software select level, and a bit that turns on the pin driver. The unit gives the shift engine an active-low internal select. It drives the pin value and the pin output enable. It raises a mode-fault flag when another master takes the bus.

There are three select sources. In software mode the internal select follows a configuration bit, and the pin is left free for other uses. In drive mode (master only), the pin goes low on the master engine's start strobe and stays low until the peripheral is disabled. In sense mode, the pin is an input: a slave treats it as its chip select, and a master in multimaster use watches it for contention. The pin input always passes through a synchronizer before any logic reads it.

Top module: `spi_sel_mgr`

## Requirements
- R1: With `cfg_sw_sel`=1, `sel_n` takes the value of `cfg_sw_level` one clock edge after it is applied, and `nss_oe` is 0 one edge after software mode is selected.
- R2: In software mode, the pin input has no effect: `sel_n` keeps following `cfg_sw_level`, and `mode_fault` stays 0.
- R3: Drive mode is selected when `cfg_sw_sel`=0, `cfg_pin_drive`=1 and the effective master bit is 1. One edge after entering drive mode, `nss_oe` is 1. The pin output stays 1 until a `xfer_start` pulse arrives while `cfg_en`=1. It is 0 one edge after that pulse.
- R4: Once low in drive mode, `nss_o` stays 0 through further start pulses while `cfg_en` stays 1. It returns to 1 one edge after `cfg_en` is cleared. `nss_oe` remains 1 while drive mode is still selected.
- R5: A `xfer_start` pulse while `cfg_en`=0 leaves `nss_o` at 1.
- R6: In sense mode, `sel_n` equals the pin input delayed by three clock edges: two synchronizer stages plus the select register. `nss_oe` is 0. A slave with `cfg_pin_drive`=1 still uses sense mode.
- R7: With `cfg_sw_sel`=0, `cfg_pin_drive`=0, `cfg_master`=1 and `cfg_en`=1, a low pin input sets `mode_fault` three edges after the pin falls. While the flag is set, `master_eff` is 0.
- R8: `mode_fault` is sticky and is cleared one edge after `fault_clr`=1. If a clear and a new fault condition occur in the same cycle, the flag stays set.
- R9: In drive mode, `sel_n` is 1.
- R10: After a clock edge with `rst_n`=0, the outputs are `nss_oe`=0, `nss_o`=1, `sel_n`=1 and `mode_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_en | input | 1 | Peripheral enable |
| cfg_master | input | 1 | 1 selects master, 0 selects slave |
| cfg_sw_sel | input | 1 | 1 selects software select mode |
| cfg_sw_level | input | 1 | Internal select level used in software mode |
| cfg_pin_drive | input | 1 | In hardware mode, 1 turns on the pin driver |
| xfer_start | input | 1 | Start strobe from the master engine |
| fault_clr | input | 1 | Clears the mode-fault flag |
| nss_i | input | 1 | Raw slave-select pin input |
| nss_o | output | 1 | Pin output value |
| nss_oe | output | 1 | Pin output enable |
| sel_n | output | 1 | Internal select for the shift engine, active low |
| master_eff | output | 1 | Master bit after mode-fault override |
| mode_fault | output | 1 | Sticky mode-fault flag |

## Verification
Setting the mode-fault flag and clearing it can fall in the same cycle. The bench causes this by holding the pin low in the multimaster setup and pulsing `fault_clr` on the same edge that sees the low synchronized level. The flag must stay set, and it must then clear once the pin is high and the clear is repeated. A start strobe can also arrive in the cycle that disables the peripheral. The bench checks that the disable wins. Random stimulus hits both cases often, and a cycle model in the bench judges every result.

// File: rtl/spi_sel_pkg.sv
// Package: shared types for the slave-select manager.
// Assumes: nothing beyond the configuration encoding described in the brief.
package spi_sel_pkg;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_DRIVE = 2'd1,
        SRC_SENSE = 2'd2
    } sel_src_e;

    // Pick the select source from configuration; the pin driver is only legal for a master.
    function automatic sel_src_e pick_source(input logic sw_sel, input logic pin_drive,
                                             input logic master);
        if (sw_sel)
            return SRC_SOFT;
        else if (pin_drive && master)
            return SRC_DRIVE;
        else
            return SRC_SENSE;
    endfunction

endpackage

// File: rtl/spi_sel_sync.sv
// Module: spi_sel_sync
// Multi-stage synchronizer for the slave-select pin input.
// Assumes: STAGES >= 2 (smaller values are raised to 2); resets to RST_VAL.
module spi_sel_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] stg;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stg <= {N{RST_VAL}};
        else
            stg <= {stg[N-2:0], d};
    end

    assign q = stg[N-1];

endmodule

// File: rtl/spi_sel_drive.sv
// Module: spi_sel_drive
// Pin output control: enables the pin in drive mode and holds it low from the
// first start strobe until the peripheral is disabled.
// Assumes: src is the decoded select source for the current cycle.
module spi_sel_drive
    import spi_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sel_src_e src,
    input  logic     en,
    input  logic     start,
    output logic     pin_o,
    output logic     pin_oe
);
    logic drv_low;
    logic oe_q;
    logic in_drive;

    assign in_drive = (src == SRC_DRIVE);

    // Register the output enable and the held-low state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q    <= 1'b0;
            drv_low <= 1'b0;
        end else begin
            oe_q    <= in_drive;
            drv_low <= in_drive && en && (drv_low || start);
        end
    end

    assign pin_o  = ~drv_low;
    assign pin_oe = oe_q;

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_drive && en && start) |=> (!pin_o && pin_oe));

    assert_low_needs_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_o |-> pin_oe);

    assert_hold_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_o && in_drive && en) |=> !pin_o);

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> pin_o);

endmodule

// File: rtl/spi_sel_fault.sv
// Module: spi_sel_fault
// Sticky mode-fault flag for multimaster use: set by a low synchronized pin
// while hardware sense mode, master and enable are all active.
// Assumes: nss_s is already synchronized; a set wins over a same-cycle clear.
module spi_sel_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_sel,
    input  logic pin_drive,
    input  logic master,
    input  logic en,
    input  logic nss_s,
    input  logic clr,
    output logic fault
);
    logic hit;

    assign hit = !sw_sel && !pin_drive && master && en && !nss_s;

    // Hold the flag until cleared; a new hit takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault <= 1'b0;
        else
            fault <= hit || (fault && !clr);
    end

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !clr) |=> fault);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && clr && nss_s) |=> !fault);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit) |=> fault);

endmodule

// File: rtl/spi_sel_mgr.sv
// Module: spi_sel_mgr (top)
// Slave-select manager: chooses the select source (software bit, driven pin,
// or sensed pin), produces the internal active-low select, controls the pin
// and reports mode faults.
// Assumes: configuration inputs are synchronous to clk; nss_i is asynchronous.
module spi_sel_mgr
    import spi_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic cfg_master,
    input  logic cfg_sw_sel,
    input  logic cfg_sw_level,
    input  logic cfg_pin_drive,
    input  logic xfer_start,
    input  logic fault_clr,
    input  logic nss_i,
    output logic nss_o,
    output logic nss_oe,
    output logic sel_n,
    output logic master_eff,
    output logic mode_fault
);
    logic     nss_s;
    logic     sel_q;
    sel_src_e src;

    spi_sel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nss_i),
        .q     (nss_s)
    );

    assign master_eff = cfg_master && !mode_fault;
    assign src        = pick_source(cfg_sw_sel, cfg_pin_drive, master_eff);

    spi_sel_drive u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src),
        .en     (cfg_en),
        .start  (xfer_start),
        .pin_o  (nss_o),
        .pin_oe (nss_oe)
    );

    spi_sel_fault u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_sel    (cfg_sw_sel),
        .pin_drive (cfg_pin_drive),
        .master    (cfg_master),
        .en        (cfg_en),
        .nss_s     (nss_s),
        .clr       (fault_clr),
        .fault     (mode_fault)
    );

    // Register the internal select from the chosen source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 1'b1;
        else begin
            case (src)
                SRC_SOFT:  sel_q <= cfg_sw_level;
                SRC_DRIVE: sel_q <= 1'b1;
                default:   sel_q <= nss_s;
            endcase
        end
    end

    assign sel_n = sel_q;

    assert_sw_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sw_sel |=> (sel_n == $past(cfg_sw_level)));

    assert_sw_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sw_sel |=> !nss_oe);

    assert_sw_nofault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sw_sel && !mode_fault) |=> !mode_fault);

    assert_fault_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_fault) |-> $past(!cfg_sw_sel && !cfg_pin_drive && cfg_master && cfg_en));

    assert_drive_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_DRIVE) |=> sel_n);

endmodule

// File: tb/sim_spi_sel_mgr.sv
module sim_spi_sel_mgr;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_master = 1'b0, cfg_sw_sel = 1'b0, cfg_sw_level = 1'b1;
    logic cfg_pin_drive = 1'b0, xfer_start = 1'b0, fault_clr = 1'b0, nss_i = 1'b1;
    logic nss_o, nss_oe, sel_n, master_eff, mode_fault;

    int vectors = 0;
    int miscomp = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    spi_sel_mgr u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_sw_sel(cfg_sw_sel), .cfg_sw_level(cfg_sw_level), .cfg_pin_drive(cfg_pin_drive),
        .xfer_start(xfer_start), .fault_clr(fault_clr), .nss_i(nss_i),
        .nss_o(nss_o), .nss_oe(nss_oe), .sel_n(sel_n), .master_eff(master_eff),
        .mode_fault(mode_fault)
    );

    // Cycle model built from the requirements.
    logic m_s1 = 1'b1, m_s2 = 1'b1, m_sel = 1'b1, m_drv = 1'b0, m_oe = 1'b0, m_flt = 1'b0;

    function automatic int model_src(input logic sw, input logic pd, input logic meff);
        if (sw) return 0;
        if (pd && meff) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_sel <= 1'b1;
            m_drv <= 1'b0; m_oe <= 1'b0; m_flt <= 1'b0;
        end else begin
            int s;
            s = model_src(cfg_sw_sel, cfg_pin_drive, cfg_master && !m_flt);
            m_s1  <= nss_i;
            m_s2  <= m_s1;
            m_oe  <= (s == 1);
            m_drv <= (s == 1) && cfg_en && (m_drv || xfer_start);
            m_sel <= (s == 0) ? cfg_sw_level : (s == 1) ? 1'b1 : m_s2;
            m_flt <= (!cfg_sw_sel && !cfg_pin_drive && cfg_master && cfg_en && !m_s2)
                     || (m_flt && !fault_clr);
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic en, input logic ms, input logic sw, input logic lvl,
                       input logic pd);
        cfg_en = en; cfg_master = ms; cfg_sw_sel = sw; cfg_sw_level = lvl; cfg_pin_drive = pd;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            miscomp++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5E1EC7));
        tick(3);
        // R10 reset values
        chk("R10", "nss_oe", nss_oe, 1'b0);
        chk("R10", "nss_o", nss_o, 1'b1);
        chk("R10", "sel_n", sel_n, 1'b1);
        chk("R10", "mode_fault", mode_fault, 1'b0);
        rst_n = 1'b1;

        // R1 software select follows level, pin released
        cfg(1, 1, 1, 1'b0, 0);
        tick(1);
        chk("R1", "sel_n", sel_n, 1'b0);
        chk("R1", "nss_oe", nss_oe, 1'b0);
        cfg_sw_level = 1'b1;
        tick(1);
        chk("R1", "sel_n", sel_n, 1'b1);
        // R2 pin ignored in software mode
        nss_i = 1'b0;
        tick(5);
        chk("R2", "sel_n", sel_n, 1'b1);
        chk("R2", "mode_fault", mode_fault, 1'b0);
        nss_i = 1'b1;
        tick(3);

        // R3 drive mode
        cfg(1, 1, 0, 1'b1, 1);
        tick(1);
        chk("R3", "nss_oe", nss_oe, 1'b1);
        chk("R3", "nss_o idle", nss_o, 1'b1);
        chk("R9", "sel_n", sel_n, 1'b1);
        xfer_start = 1'b1;
        tick(1);
        xfer_start = 1'b0;
        chk("R3", "nss_o after start", nss_o, 1'b0);
        tick(4);
        xfer_start = 1'b1;
        tick(1);
        xfer_start = 1'b0;
        chk("R4", "nss_o held", nss_o, 1'b0);
        // R4 disable together with a start strobe
        cfg_en = 1'b0; xfer_start = 1'b1;
        tick(1);
        chk("R4", "nss_o released", nss_o, 1'b1);
        chk("R4", "nss_oe kept", nss_oe, 1'b1);
        // R5 start while disabled
        tick(2);
        xfer_start = 1'b0;
        chk("R5", "nss_o", nss_o, 1'b1);

        // R6 slave sense mode, three edge latency
        cfg(1, 0, 0, 1'b1, 1);
        tick(4);
        chk("R6", "nss_oe slave", nss_oe, 1'b0);
        nss_i = 1'b0;
        tick(2);
        chk("R6", "sel_n before", sel_n, 1'b1);
        tick(1);
        chk("R6", "sel_n after", sel_n, 1'b0);
        nss_i = 1'b1;
        tick(3);
        chk("R6", "sel_n high", sel_n, 1'b1);

        // R7 multimaster fault
        cfg(1, 1, 0, 1'b1, 0);
        tick(3);
        chk("R7", "master_eff", master_eff, 1'b1);
        nss_i = 1'b0;
        tick(2);
        chk("R7", "mode_fault early", mode_fault, 1'b0);
        tick(1);
        chk("R7", "mode_fault", mode_fault, 1'b1);
        chk("R7", "master_eff", master_eff, 1'b0);
        // R8 clear against a live fault condition: set wins
        fault_clr = 1'b1;
        tick(1);
        fault_clr = 1'b0;
        chk("R8", "set wins", mode_fault, 1'b1);
        nss_i = 1'b1;
        tick(5);
        chk("R8", "sticky", mode_fault, 1'b1);
        fault_clr = 1'b1;
        tick(1);
        fault_clr = 1'b0;
        chk("R8", "cleared", mode_fault, 1'b0);
        chk("R8", "master_eff back", master_eff, 1'b1);

        // Random phase checked against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (($urandom % 16) == 0) begin
                cfg_sw_sel    = ($urandom % 3) == 0;
                cfg_pin_drive = $urandom % 2;
                cfg_master    = $urandom % 2;
            end
            if (($urandom % 4) == 0) cfg_sw_level = $urandom % 2;
            if (($urandom % 10) == 0) cfg_en = ~cfg_en;
            if (($urandom % 5) == 0) nss_i = ~nss_i;
            xfer_start = ($urandom % 4) == 0;
            fault_clr  = ($urandom % 6) == 0;
            rst_n      = ($urandom % 500) != 0;
            tick(1);
            if (!rst_n) begin
                chk("R10", "nss_oe", nss_oe, m_oe);
                chk("R10", "sel_n", sel_n, m_sel);
            end else begin
                chk(cfg_sw_sel ? "R1" : "R6", "sel_n", sel_n, m_sel);
                chk(cfg_sw_sel ? "R1" : "R3", "nss_oe", nss_oe, m_oe);
                chk("R4", "nss_o", nss_o, !m_drv);
                chk("R8", "mode_fault", mode_fault, m_flt);
                chk("R7", "master_eff", master_eff, cfg_master && !m_flt);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule